// File: doc/BRIEF.md
# Data-Line Stuck-Low Recovery Sequencer

This block frees a two-wire serial bus whose data line is held low by another device, for example a target that has lost count of its bit position. A master controller asks it to issue a START condition through a single trigger input. If the data line is already high, the START goes out at once. If the data line is low, the block takes over both lines with no host action. It toggles the clock a fixed number of times so the stuck device can finish its byte, then attempts a STOP. It decides from the data line whether the bus has been recovered.

On success it issues a normal START, reports the "start sent" status code, and raises its interrupt while holding the clock low, as a master does after a START. The rest of the controller then carries on with the transfer. On failure it releases both lines, reports the "data stuck" status code and raises its interrupt. That fault stays until an external reset. Both lines are open-drain: each output is a drive-low enable. The timing of every clock phase comes from a half-period tick that the clock-rate generator supplies.

Top module: `sda_recover_seq`

## Requirements
- R1: After reset, status is 0xF8, irq is 0, and both scl_oe and sda_oe are 0 (lines released).
- R2: A trigger while the (synchronised) data line is low starts exactly PULSES (default 9) clock pulses. Each pulse is one low phase and one high phase, each lasting one half_tick period, so successive falling clock edges are two tick periods apart.
- R3: After the last pulse a STOP is attempted. The clock is driven low with data driven low, then the clock is released, then data is released, one tick each.
- R4: The data line is sampled at the end of the last clock-high phase. If it was high, a START is sent (data falls while clock is high, then clock is driven low), status becomes 0x08, irq rises, and both lines stay driven low.
- R5: If that sample was low, status becomes 0x70, irq rises, and both lines are released.
- R6: The 0x70 failure is latched. Trigger and irq_clr have no effect on status, irq or the lines until rst_n is asserted.
- R7: A trigger while the data line is high sends a START directly with no clock pulses and no STOP, ending with status 0x08 and irq 1.
- R8: irq_clr in the 0x08 state returns status to 0xF8, drops irq and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; the only way out of the fault |
| half_tick | input | 1 | One-cycle pulse marking each half period of the bus clock |
| trigger | input | 1 | Request to send a START; accepted only when idle |
| irq_clr | input | 1 | Acknowledge of the 0x08 interrupt |
| sda_in | input | 1 | Sampled level of the data line |
| scl_oe | output | 1 | Drive clock line low when 1 |
| sda_oe | output | 1 | Drive data line low when 1 |
| status | output | 8 | Status code: 0xF8 idle, 0x08 START sent, 0x70 data stuck |
| irq | output | 1 | Interrupt request, set with 0x08 or 0x70 |

## Verification
The embedded properties check every cycle that the sequencer only moves on a tick, trigger or acknowledge, and that the STOP never begins before the last pulse. They also check that the interrupt only accompanies the two defined codes, and that the stuck-data fault holds with both lines released. Only the bench's bus model can show the pulse count, the spacing of clock edges, the STOP and START conditions seen on the wires, and the pass/fail outcome. It does this by releasing the data line at different clock edges relative to the sample point, including one edge too late.

// File: rtl/sda_recover_pkg.sv
package sda_recover_pkg;

   typedef enum logic [3:0] {
      ST_IDLE     = 4'd0,
      ST_PULSE_LO = 4'd1,
      ST_PULSE_HI = 4'd2,
      ST_STOP_LO  = 4'd3,
      ST_STOP_HI  = 4'd4,
      ST_STOP_REL = 4'd5,
      ST_START_A  = 4'd6,
      ST_START_B  = 4'd7,
      ST_HELD     = 4'd8,
      ST_FAULT    = 4'd9
   } seq_state_t;

   typedef struct packed {
      logic scl_drive;
      logic sda_drive;
   } line_drive_t;

endpackage

// File: rtl/rsq_pulse_counter.sv
module rsq_pulse_counter #(
   parameter int PULSES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int CNT_W = (PULSES > 1) ? $clog2(PULSES) : 1;
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PULSES - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (PULSES < 1) begin : g_bad_pulses
         $error("rsq_pulse_counter: PULSES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != LAST_VAL)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/rsq_sda_sampler.sv
module rsq_sda_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_in,
   input  logic capture,
   output logic sda_now,
   output logic sda_free
);
   logic free_q;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("rsq_sda_sampler: SYNC_STAGES must be 0 to 4");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign sda_now = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q <= {chain_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], sda_in};
            end
         end
         assign sda_now = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q <= 1'b0;
      end else if (capture) begin
         free_q <= sda_now;
      end
   end

   assign sda_free = free_q;

endmodule

// File: rtl/rsq_status_reg.sv
module rsq_status_reg #(
   parameter int         CODE_W    = 8,
   parameter logic [7:0] CODE_IDLE = 8'hF8,
   parameter logic [7:0] CODE_OK   = 8'h08,
   parameter logic [7:0] CODE_FAIL = 8'h70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_ok,
   input  logic              set_fail,
   input  logic              clr_ok,
   output logic [CODE_W-1:0] status,
   output logic              irq,
   output logic              failed
);
   logic [CODE_W-1:0] status_q;
   logic              irq_q;
   logic              fail_q;

   generate
      if (CODE_W < 8) begin : g_bad_width
         $error("rsq_status_reg: CODE_W must hold an 8-bit code");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= CODE_W'(CODE_IDLE);
         irq_q    <= 1'b0;
         fail_q   <= 1'b0;
      end else if (!fail_q) begin
         if (set_fail) begin
            status_q <= CODE_W'(CODE_FAIL);
            irq_q    <= 1'b1;
            fail_q   <= 1'b1;
         end else if (set_ok) begin
            status_q <= CODE_W'(CODE_OK);
            irq_q    <= 1'b1;
         end else if (clr_ok) begin
            status_q <= CODE_W'(CODE_IDLE);
            irq_q    <= 1'b0;
         end
      end
   end

   assign status = status_q;
   assign irq    = irq_q;
   assign failed = fail_q;

   // R6: once the stuck-data code is loaded it stays until reset
   a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == CODE_W'(CODE_FAIL)) |=> (status_q == CODE_W'(CODE_FAIL)));

   // R4 / R5: the interrupt is only raised with one of the two defined codes
   a_r4_irq_codes: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ((status_q == CODE_W'(CODE_OK)) || (status_q == CODE_W'(CODE_FAIL))));

endmodule

// File: rtl/sda_recover_seq.sv
module sda_recover_seq
   import sda_recover_pkg::*;
#(
   parameter int         PULSES      = 9,
   parameter int         SYNC_STAGES = 2,
   parameter int         CODE_W      = 8,
   parameter logic [7:0] CODE_IDLE   = 8'hF8,
   parameter logic [7:0] CODE_OK     = 8'h08,
   parameter logic [7:0] CODE_FAIL   = 8'h70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick,
   input  logic              trigger,
   input  logic              irq_clr,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic [CODE_W-1:0] status,
   output logic              irq
);
   seq_state_t  state_q, state_d;
   line_drive_t drive;

   logic pulse_last;
   logic pulse_clr;
   logic pulse_inc;
   logic sda_now;
   logic sda_free;
   logic capture;
   logic set_ok;
   logic set_fail;
   logic clr_ok;
   logic failed;

   rsq_pulse_counter #(
      .PULSES (PULSES)
   ) u_pulse_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pulse_clr),
      .inc   (pulse_inc),
      .last  (pulse_last)
   );

   rsq_sda_sampler #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_in   (sda_in),
      .capture  (capture),
      .sda_now  (sda_now),
      .sda_free (sda_free)
   );

   rsq_status_reg #(
      .CODE_W    (CODE_W),
      .CODE_IDLE (CODE_IDLE),
      .CODE_OK   (CODE_OK),
      .CODE_FAIL (CODE_FAIL)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_ok   (set_ok),
      .set_fail (set_fail),
      .clr_ok   (clr_ok),
      .status   (status),
      .irq      (irq),
      .failed   (failed)
   );

   // next-state and strobes
   always_comb begin
      state_d   = state_q;
      pulse_clr = 1'b0;
      pulse_inc = 1'b0;
      capture   = 1'b0;
      set_ok    = 1'b0;
      set_fail  = 1'b0;
      clr_ok    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (trigger) begin
               pulse_clr = 1'b1;
               state_d   = sda_now ? ST_START_A : ST_PULSE_LO;
            end
         end
         ST_PULSE_LO: begin
            if (half_tick) state_d = ST_PULSE_HI;
         end
         ST_PULSE_HI: begin
            if (half_tick) begin
               if (pulse_last) begin
                  capture = 1'b1;
                  state_d = ST_STOP_LO;
               end else begin
                  pulse_inc = 1'b1;
                  state_d   = ST_PULSE_LO;
               end
            end
         end
         ST_STOP_LO: begin
            if (half_tick) state_d = ST_STOP_HI;
         end
         ST_STOP_HI: begin
            if (half_tick) state_d = ST_STOP_REL;
         end
         ST_STOP_REL: begin
            if (half_tick) begin
               if (sda_free) begin
                  state_d = ST_START_A;
               end else begin
                  set_fail = 1'b1;
                  state_d  = ST_FAULT;
               end
            end
         end
         ST_START_A: begin
            if (half_tick) state_d = ST_START_B;
         end
         ST_START_B: begin
            if (half_tick) begin
               set_ok  = 1'b1;
               state_d = ST_HELD;
            end
         end
         ST_HELD: begin
            if (irq_clr) begin
               clr_ok  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_FAULT: begin
            state_d = ST_FAULT;
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   // line drive per state
   always_comb begin
      drive = '{scl_drive: 1'b0, sda_drive: 1'b0};
      unique case (state_q)
         ST_PULSE_LO: drive = '{scl_drive: 1'b1, sda_drive: 1'b0};
         ST_STOP_LO:  drive = '{scl_drive: 1'b1, sda_drive: 1'b1};
         ST_STOP_HI:  drive = '{scl_drive: 1'b0, sda_drive: 1'b1};
         ST_START_A:  drive = '{scl_drive: 1'b0, sda_drive: 1'b1};
         ST_START_B:  drive = '{scl_drive: 1'b1, sda_drive: 1'b1};
         ST_HELD:     drive = '{scl_drive: 1'b1, sda_drive: 1'b1};
         default:     drive = '{scl_drive: 1'b0, sda_drive: 1'b0};
      endcase
   end

   assign scl_oe = drive.scl_drive;
   assign sda_oe = drive.sda_drive;

   // R2: the sequence only advances on a tick, a trigger or an acknowledge
   a_r2_phase_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != $past(state_q)) |-> ($past(half_tick) || $past(trigger) || $past(irq_clr)));

   // R3: the STOP attempt only follows the final pulse
   a_r3_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_STOP_LO) && ($past(state_q) == ST_PULSE_HI)) |-> $past(pulse_last));

   // R5: in the fault both lines are let go
   a_r5_fault_released: assert property (@(posedge clk) disable iff (!rst_n)
      failed |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/test_sda_recover_seq.sv
module test_sda_recover_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       half_tick = 1'b0;
   logic       trigger = 1'b0;
   logic       irq_clr = 1'b0;
   logic       sda_in;
   logic       scl_oe, sda_oe, irq;
   logic [7:0] status;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   // bus model state
   logic slave_low = 1'b0;
   int   hold_k    = 0;
   logic mon_clr   = 1'b0;
   int   falls = 0, starts = 0, stops = 0;
   int   t_first = 0, t_ninth = 0;
   logic scl_prev = 1'b1, sda_prev = 1'b1;
   logic scl_line, sda_line;
   int   tick_div = 0;

   assign scl_line = ~scl_oe;
   assign sda_line = ~(sda_oe | slave_low);
   assign sda_in   = sda_line;

   sda_recover_seq i_sda_recover_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_tick (half_tick),
      .trigger   (trigger),
      .irq_clr   (irq_clr),
      .sda_in    (sda_in),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe),
      .status    (status),
      .irq       (irq)
   );

   always #10 clk = ~clk;

   // tick every 4 cycles, bus monitor and target model, all on the falling edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      tick_div = (tick_div + 1) % 4;
      half_tick = (tick_div == 0);
      if (mon_clr) begin
         slave_low = (hold_k != 0);
         falls = 0; starts = 0; stops = 0; t_first = 0; t_ninth = 0;
         scl_prev = scl_line;
         sda_prev = ~(sda_oe | slave_low);
      end else begin
         if (scl_prev && !scl_line) begin
            falls = falls + 1;
            if (falls == 1) t_first = cyc;
            if (falls == 9) t_ninth = cyc;
            if (falls == hold_k) slave_low = 1'b0;
         end
         if (scl_prev && scl_line && sda_prev && !sda_line) starts = starts + 1;
         if (scl_prev && scl_line && !sda_prev && sda_line) stops = stops + 1;
         scl_prev = scl_line;
         sda_prev = ~(sda_oe | slave_low);
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset(input int k);
      @(negedge clk);
      rst_n   = 1'b0;
      hold_k  = k;
      mon_clr = 1'b1;
      wait_cycles(3);
      mon_clr = 1'b0;
      rst_n   = 1'b1;
      wait_cycles(4);
   endtask

   task automatic fire_and_wait;
      trigger = 1'b1;
      @(negedge clk);
      trigger = 1'b0;
      for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
      wait_cycles(3);
   endtask

   // release edge, status, falls, starts, stops, lines held
   localparam int NV = 6;
   localparam int VEC [NV][6] = '{
      '{0,   8'h08, 1,  1, 0, 1},   // R7: direct START
      '{1,   8'h08, 11, 1, 1, 1},   // R4: early release
      '{6,   8'h08, 11, 1, 1, 1},   // R4
      '{9,   8'h08, 11, 1, 1, 1},   // R4: released on last pulse
      '{10,  8'h70, 10, 0, 1, 0},   // R5: one edge too late
      '{255, 8'h70, 10, 0, 0, 0}    // R5: never released
   };

   initial begin
      // R1: reset state
      wait_cycles(3);
      check("R1", "status", status, 8'hF8);
      check("R1", "irq", irq, 0);
      check("R1", "scl_oe", scl_oe, 0);
      check("R1", "sda_oe", sda_oe, 0);

      for (int v = 0; v < NV; v++) begin
         do_reset(VEC[v][0]);
         fire_and_wait();
         check(VEC[v][1] == 8'h08 ? "R4" : "R5", "status", status, VEC[v][1]);
         check("R4", "irq", irq, 1);
         check("R2", "scl falls", falls, VEC[v][2]);
         check("R4", "start conditions", starts, VEC[v][3]);
         check("R3", "stop conditions", stops, VEC[v][4]);
         check("R5", "scl_oe", scl_oe, VEC[v][5]);
         check("R5", "sda_oe", sda_oe, VEC[v][5]);
         if (VEC[v][0] != 0)
            check("R2", "first-to-ninth fall cycles", t_ninth - t_first, 64);
      end

      // R6: fault ignores trigger and acknowledge
      do_reset(255);
      fire_and_wait();
      irq_clr = 1'b1; trigger = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0; trigger = 1'b0;
      wait_cycles(40);
      check("R6", "status kept", status, 8'h70);
      check("R6", "irq kept", irq, 1);
      check("R6", "no new falls", falls, 10);
      check("R6", "scl_oe", scl_oe, 0);
      do_reset(0);
      check("R6", "reset clears fault", status, 8'hF8);

      // R8: acknowledge after success
      do_reset(0);
      fire_and_wait();
      check("R7", "direct start status", status, 8'h08);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      wait_cycles(2);
      check("R8", "status", status, 8'hF8);
      check("R8", "irq", irq, 0);
      check("R8", "scl_oe", scl_oe, 0);
      check("R8", "sda_oe", sda_oe, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      wait_cycles(100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule